// File: doc/BRIEF.md
# Load Ordering Violation Checker

This block holds a circular queue of in-flight loads and, whenever a memory instruction resolves its address, walks the loads younger than that instruction to find memory ordering violations. The resolving instruction's kind (load or store), sequence number, byte range and queue position are presented on a request port. While the scan runs, the block visits one queue entry per clock. When it ends, the block pulses a done flag, and it pulses a squash request if any violation was found. The oldest violating load seen since the last acknowledge is held for the flush logic, and a saturating counter tallies every violating entry.

Addresses are compared in coarse blocks, not bytes. A younger load that overlaps a resolving store is a violation only if it has already executed. A younger load that overlaps a resolving load is a violation only if an external invalidation has touched it. If it has not, the younger load is marked as a possible violation. A later invalidating snoop then turns that mark into a re-execute flag. Entries are loaded through a write port that also clears their marks.

Top module: `lvc_checker`

## Requirements
- R1: After reset the block is idle: chk_busy, chk_done, squash_req and viol_valid are 0, viol_count is 0, and the snooped, possible and reexec masks are all zero.
- R2: A request is accepted only while idle. The scan visits positions chk_pos+1, chk_pos+2, … modulo DEPTH, one per clock, and stops on reaching tail_idx. For N visited entries, chk_done is high for one cycle, N+1 clocks after the accepting edge, and chk_busy is low from then on. chk_valid is ignored while busy.
- R3: Two ranges overlap when (req_hi >> DEP_SHIFT) >= (ent_lo >> DEP_SHIFT) and (req_lo >> DEP_SHIFT) <= (ent_hi >> DEP_SHIFT). Both bounds are inclusive.
- R4: An entry is skipped if any of these holds: its address-valid bit is 0, its strictly-ordered bit is 1, or its sequence number is not younger than chk_seq.
- R5: On a store request (chk_store=1), an overlapping executed entry is a violation. An overlapping entry that has not executed changes nothing.
- R6: On a load request (chk_store=0), an overlapping entry whose snooped mark is set is a violation. Otherwise that entry's possible mark is set.
- R7: viol_seq/viol_idx hold the oldest violator since the last viol_ack. A new violator replaces the held one only if it is older. "Older" means that bit SEQW-1 of (a-b) is 1. viol_ack clears viol_valid.
- R8: squash_req pulses in the same cycle as chk_done exactly when the scan found at least one violation.
- R9: viol_count rises by one for each violating entry and saturates at all ones (CNTW bits).
- R10: A snoop hits an entry whose address is valid and not strictly ordered, when snp_addr >> LINE_SHIFT lies between ent_lo >> LINE_SHIFT and ent_hi >> LINE_SHIFT. A hit sets the entry's snooped mark. If the possible mark was already set before that cycle, the hit also sets reexec. A snoop and a scan step in the same cycle each see the other's marks as they stood before that cycle.
- R11: An entry write loads sequence number, range and the address-valid, strictly-ordered and executed bits, and clears that entry's snooped, possible and reexec marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDXW | Entry index to write |
| wr_seq | input | SEQW | Sequence number of written load |
| wr_lo | input | ADDRW | First byte of written load |
| wr_hi | input | ADDRW | Last byte of written load |
| wr_addr_ok | input | 1 | Effective address valid |
| wr_strict | input | 1 | Load is strictly ordered |
| wr_exec | input | 1 | Load has executed |
| tail_idx | input | IDXW | Position one past the youngest load |
| chk_valid | input | 1 | Resolving-instruction request |
| chk_store | input | 1 | 1 = store, 0 = load |
| chk_seq | input | SEQW | Sequence number of resolving instruction |
| chk_lo | input | ADDRW | First byte of resolving access |
| chk_hi | input | ADDRW | Last byte of resolving access |
| chk_pos | input | IDXW | Queue position of resolving instruction |
| snp_valid | input | 1 | Invalidating snoop strobe |
| snp_addr | input | ADDRW | Snoop address |
| viol_ack | input | 1 | Clears the held violator |
| chk_busy | output | 1 | Scan in progress |
| chk_done | output | 1 | One-cycle end-of-scan pulse |
| squash_req | output | 1 | One-cycle squash pulse with chk_done |
| viol_valid | output | 1 | A violator is held |
| viol_seq | output | SEQW | Sequence number of held violator |
| viol_idx | output | IDXW | Queue index of held violator |
| viol_count | output | CNTW | Saturating violation tally |
| snooped | output | DEPTH | Per-entry snooped marks |
| possible | output | DEPTH | Per-entry possible-violation marks |
| reexec | output | DEPTH | Per-entry re-execute flags |

## Verification
The clash that matters is a snoop arriving in the same clock in which the scan visits the snooped entry. A load scan and a snoop are steered so that the first entry visited is also the only one in the snooped line. The bench then expects the entry to end up both snooped and possible, with no re-execute flag and no violation, because each side acted on the other's old marks. A second snoop must then raise re-execute, and a repeated load scan must now report that entry as a violator. A randomised sweep over small queues repeats store and load scans with interleaved snoops, and compares timing, held violator, count and all three masks with an arithmetic model.

// File: rtl/lvc_pkg.sv
package lvc_pkg;
    typedef struct packed {
        logic ok;
        logic strict;
        logic exec;
        logic snooped;
        logic possible;
        logic reexec;
    } ent_flags_t;
endpackage

// File: rtl/lvc_seq_age.sv
module lvc_seq_age #(
    parameter int SEQW = 16
) (
    input  logic [SEQW-1:0] a,
    input  logic [SEQW-1:0] b,
    output logic            a_older
);
    logic [SEQW-1:0] diff;
    assign diff    = a - b;
    assign a_older = diff[SEQW-1];
endmodule

// File: rtl/lvc_range_cmp.sv
module lvc_range_cmp #(
    parameter int ADDRW = 16,
    parameter int SHIFT = 3
) (
    input  logic [ADDRW-1:0] a_lo,
    input  logic [ADDRW-1:0] a_hi,
    input  logic [ADDRW-1:0] b_lo,
    input  logic [ADDRW-1:0] b_hi,
    output logic             hit
);
    localparam int KW = ADDRW - SHIFT;
    logic [KW-1:0] al, ah, bl, bh;
    assign al  = a_lo[ADDRW-1:SHIFT];
    assign ah  = a_hi[ADDRW-1:SHIFT];
    assign bl  = b_lo[ADDRW-1:SHIFT];
    assign bh  = b_hi[ADDRW-1:SHIFT];
    assign hit = (ah >= bl) && (al <= bh);
endmodule

// File: rtl/lvc_checker.sv
module lvc_checker
    import lvc_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int SEQW       = 16,
    parameter int ADDRW      = 16,
    parameter int DEP_SHIFT  = 3,
    parameter int LINE_SHIFT = 5,
    parameter int CNTW       = 16,
    localparam int IDXW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [SEQW-1:0]  wr_seq,
    input  logic [ADDRW-1:0] wr_lo,
    input  logic [ADDRW-1:0] wr_hi,
    input  logic             wr_addr_ok,
    input  logic             wr_strict,
    input  logic             wr_exec,
    input  logic [IDXW-1:0]  tail_idx,
    input  logic             chk_valid,
    input  logic             chk_store,
    input  logic [SEQW-1:0]  chk_seq,
    input  logic [ADDRW-1:0] chk_lo,
    input  logic [ADDRW-1:0] chk_hi,
    input  logic [IDXW-1:0]  chk_pos,
    input  logic             snp_valid,
    input  logic [ADDRW-1:0] snp_addr,
    input  logic             viol_ack,
    output logic             chk_busy,
    output logic             chk_done,
    output logic             squash_req,
    output logic             viol_valid,
    output logic [SEQW-1:0]  viol_seq,
    output logic [IDXW-1:0]  viol_idx,
    output logic [CNTW-1:0]  viol_count,
    output logic [DEPTH-1:0] snooped,
    output logic [DEPTH-1:0] possible,
    output logic [DEPTH-1:0] reexec
);
    localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};
    localparam logic [IDXW-1:0] LAST    = IDXW'(DEPTH - 1);

    typedef struct packed {
        logic                              busy;
        logic                              done;
        logic                              squash;
        logic                              found;
        logic                              store;
        logic [SEQW-1:0]                   cseq;
        logic [ADDRW-1:0]                  clo;
        logic [ADDRW-1:0]                  chi;
        logic [IDXW-1:0]                   ptr;
        logic                              vvalid;
        logic [SEQW-1:0]                   vseq;
        logic [IDXW-1:0]                   vidx;
        logic [CNTW-1:0]                   cnt;
        logic [DEPTH-1:0][ADDRW-1:0]       lo;
        logic [DEPTH-1:0][ADDRW-1:0]       hi;
        logic [DEPTH-1:0][SEQW-1:0]        seq;
        ent_flags_t [DEPTH-1:0]            flg;
    } state_t;

    state_t s_q, s_d;

    function automatic logic [IDXW-1:0] bump(input logic [IDXW-1:0] p);
        return (p == LAST) ? '0 : IDXW'(p + 1'b1);
    endfunction

    // Entry under the scan pointer
    logic [ADDRW-1:0] cur_lo, cur_hi;
    logic [SEQW-1:0]  cur_seq;
    ent_flags_t       cur_flg;
    logic             ovl_hit, cur_younger, cur_older, viol_now;
    logic [DEPTH-1:0] snp_line_hit;

    assign cur_lo  = s_q.lo[s_q.ptr];
    assign cur_hi  = s_q.hi[s_q.ptr];
    assign cur_seq = s_q.seq[s_q.ptr];
    assign cur_flg = s_q.flg[s_q.ptr];

    lvc_range_cmp #(.ADDRW(ADDRW), .SHIFT(DEP_SHIFT)) u_ovl (
        .a_lo(s_q.clo), .a_hi(s_q.chi), .b_lo(cur_lo), .b_hi(cur_hi), .hit(ovl_hit)
    );
    lvc_seq_age #(.SEQW(SEQW)) u_young (
        .a(s_q.cseq), .b(cur_seq), .a_older(cur_younger)
    );
    lvc_seq_age #(.SEQW(SEQW)) u_oldest (
        .a(cur_seq), .b(s_q.vseq), .a_older(cur_older)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_snp
        lvc_range_cmp #(.ADDRW(ADDRW), .SHIFT(LINE_SHIFT)) u_line (
            .a_lo(snp_addr), .a_hi(snp_addr),
            .b_lo(s_q.lo[g]), .b_hi(s_q.hi[g]), .hit(snp_line_hit[g])
        );
        assign snooped[g]  = s_q.flg[g].snooped;
        assign possible[g] = s_q.flg[g].possible;
        assign reexec[g]   = s_q.flg[g].reexec;
    end

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.squash = 1'b0;
        viol_now   = 1'b0;
        if (viol_ack) s_d.vvalid = 1'b0;

        if (s_q.busy) begin
            if (s_q.ptr == tail_idx) begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.squash = s_q.found;
            end else begin
                if (cur_flg.ok && !cur_flg.strict && cur_younger && ovl_hit) begin
                    if (s_q.store)            viol_now = cur_flg.exec;
                    else if (cur_flg.snooped) viol_now = 1'b1;
                    else                      s_d.flg[s_q.ptr].possible = 1'b1;
                end
                if (viol_now) begin
                    s_d.found = 1'b1;
                    if (s_q.cnt != CNT_MAX) s_d.cnt = s_q.cnt + 1'b1;
                    if (!s_d.vvalid || cur_older) begin
                        s_d.vvalid = 1'b1;
                        s_d.vseq   = cur_seq;
                        s_d.vidx   = s_q.ptr;
                    end
                end
                s_d.ptr = bump(s_q.ptr);
            end
        end else if (chk_valid) begin
            s_d.busy  = 1'b1;
            s_d.found = 1'b0;
            s_d.store = chk_store;
            s_d.cseq  = chk_seq;
            s_d.clo   = chk_lo;
            s_d.chi   = chk_hi;
            s_d.ptr   = bump(chk_pos);
        end

        // Snoop acts on marks as they stood before this cycle
        for (int i = 0; i < DEPTH; i++) begin
            if (snp_valid && snp_line_hit[i] && s_q.flg[i].ok && !s_q.flg[i].strict) begin
                s_d.flg[i].snooped = 1'b1;
                if (s_q.flg[i].possible) s_d.flg[i].reexec = 1'b1;
            end
        end

        if (wr_en) begin
            s_d.lo[wr_idx]           = wr_lo;
            s_d.hi[wr_idx]           = wr_hi;
            s_d.seq[wr_idx]          = wr_seq;
            s_d.flg[wr_idx]          = '0;
            s_d.flg[wr_idx].ok       = wr_addr_ok;
            s_d.flg[wr_idx].strict   = wr_strict;
            s_d.flg[wr_idx].exec     = wr_exec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign chk_busy   = s_q.busy;
    assign chk_done   = s_q.done;
    assign squash_req = s_q.squash;
    assign viol_valid = s_q.vvalid;
    assign viol_seq   = s_q.vseq;
    assign viol_idx   = s_q.vidx;
    assign viol_count = s_q.cnt;

    // R2: done only follows a running scan, and the scan has stopped by then
    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> ($past(chk_busy) && !chk_busy));
    // R8: squash is only ever raised together with done
    p_squash_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |-> chk_done);
    // R9: the tally moves only during a scan
    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_busy |=> $stable(viol_count));
    // R9: the tally stays at all ones once there
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_count == CNT_MAX) |=> (viol_count == CNT_MAX));
    // R7: a held violator is dropped only by an acknowledge
    p_hold_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !viol_ack) |=> viol_valid);
    // R10: a re-execute flag never stands without the possible mark
    p_reexec_possible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reexec & ~possible) == '0);
endmodule

// File: tb/lvc_checker_test.sv
`timescale 1ns/1ps
module lvc_checker_test;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_addr_ok = 0, wr_strict = 0, wr_exec = 0;
    logic [2:0]  wr_idx = 0, tail_idx = 0, chk_pos = 0;
    logic [15:0] wr_seq = 0, wr_lo = 0, wr_hi = 0;
    logic        chk_valid = 0, chk_store = 0, snp_valid = 0, viol_ack = 0;
    logic [15:0] chk_seq = 0, chk_lo = 0, chk_hi = 0, snp_addr = 0;
    logic        chk_busy, chk_done, squash_req, viol_valid;
    logic [15:0] viol_seq;
    logic [2:0]  viol_idx;
    logic [3:0]  viol_count;
    logic [7:0]  snooped, possible, reexec;

    lvc_checker #(.DEPTH(D), .CNTW(4)) uut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference state
    logic [15:0] m_lo[D], m_hi[D], m_seq[D];
    bit m_ok[D], m_st[D], m_ex[D], m_sn[D], m_po[D], m_rx[D];
    bit mv = 0; logic [15:0] mvseq = 0; int mvidx = 0; int mcnt = 0; int m_tail = 0;

    task automatic check(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit older(logic [15:0] a, logic [15:0] b);
        logic [15:0] d = a - b;
        return d[15];
    endfunction

    function automatic logic [7:0] mask(int which);
        logic [7:0] m = 0;
        for (int i = 0; i < D; i++)
            m[i] = (which == 0) ? m_sn[i] : (which == 1) ? m_po[i] : m_rx[i];
        return m;
    endfunction

    task automatic wr_ent(int i, logic [15:0] sq, logic [15:0] lo, logic [15:0] hi,
                          bit ok, bit st, bit ex);
        wr_en = 1; wr_idx = 3'(i); wr_seq = sq; wr_lo = lo; wr_hi = hi;
        wr_addr_ok = ok; wr_strict = st; wr_exec = ex;
        @(negedge clk); wr_en = 0;
        m_lo[i] = lo; m_hi[i] = hi; m_seq[i] = sq; m_ok[i] = ok; m_st[i] = st; m_ex[i] = ex;
        m_sn[i] = 0; m_po[i] = 0; m_rx[i] = 0;
    endtask

    task automatic do_snoop(logic [15:0] a);
        snp_valid = 1; snp_addr = a;
        @(negedge clk); snp_valid = 0;
        for (int i = 0; i < D; i++)
            if (m_ok[i] && !m_st[i] && (a / 32 >= m_lo[i] / 32) && (a / 32 <= m_hi[i] / 32)) begin
                if (m_po[i]) m_rx[i] = 1;
                m_sn[i] = 1;
            end
    endtask

    task automatic do_ack();
        viol_ack = 1; @(negedge clk); viol_ack = 0; mv = 0;
    endtask

    task automatic set_tail(int t);
        m_tail = t; tail_idx = 3'(t);
    endtask

    task automatic final_checks(string tag, int cyc, int steps, int nv);
        check("R2", {tag, " done timing"}, cyc, steps + 1);
        check("R8", {tag, " squash"}, squash_req, nv > 0);
        check("R7", {tag, " viol_valid"}, viol_valid, mv);
        if (mv) begin
            check("R7", {tag, " viol_seq"}, viol_seq, mvseq);
            check("R7", {tag, " viol_idx"}, viol_idx, mvidx);
        end
        check("R9", {tag, " count"}, viol_count, mcnt);
        check("R6", {tag, " possible mask"}, possible, mask(1));
        check("R10", {tag, " snooped mask"}, snooped, mask(0));
        check("R10", {tag, " reexec mask"}, reexec, mask(2));
    endtask

    task automatic run_scan(string tag, bit st, logic [15:0] sq, logic [15:0] lo,
                            logic [15:0] hi, int pos);
        int p = (pos + 1) % D;
        int steps = 0, nv = 0, cyc = 0;
        while (p != m_tail) begin
            if (m_ok[p] && !m_st[p] && older(sq, m_seq[p]) &&
                (hi / 8 >= m_lo[p] / 8) && (lo / 8 <= m_hi[p] / 8)) begin
                bit v = 0;
                if (st) v = m_ex[p];
                else if (m_sn[p]) v = 1;
                else m_po[p] = 1;
                if (v) begin
                    nv++;
                    if (!mv || older(m_seq[p], mvseq)) begin
                        mv = 1; mvseq = m_seq[p]; mvidx = p;
                    end
                end
            end
            p = (p + 1) % D; steps++;
        end
        mcnt = (mcnt + nv > 15) ? 15 : mcnt + nv;
        chk_valid = 1; chk_store = st; chk_seq = sq; chk_lo = lo; chk_hi = hi; chk_pos = 3'(pos);
        @(negedge clk); chk_valid = 0;
        while (!chk_done && cyc < 40) begin @(negedge clk); cyc++; end
        final_checks(tag, cyc, steps, nv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int i = 0; i < D; i++) begin
            m_lo[i] = 0; m_hi[i] = 0; m_seq[i] = 0;
            m_ok[i] = 0; m_st[i] = 0; m_ex[i] = 0; m_sn[i] = 0; m_po[i] = 0; m_rx[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy", chk_busy, 0);
        check("R1", "viol_valid", viol_valid, 0);
        check("R1", "count", viol_count, 0);
        check("R1", "masks", {snooped, possible, reexec}, 0);

        // R10 snoop in the same cycle as the scan visits the entry
        wr_ent(0, 16'd10, 16'd0,   16'd3,   1, 0, 0);
        wr_ent(1, 16'd12, 16'd64,  16'd67,  1, 0, 0);
        wr_ent(2, 16'd14, 16'd128, 16'd131, 1, 0, 0);
        wr_ent(3, 16'd16, 16'd200, 16'd203, 1, 0, 0);
        set_tail(4);
        chk_valid = 1; chk_store = 0; chk_seq = 16'd11; chk_lo = 16'd64; chk_hi = 16'd64; chk_pos = 0;
        @(negedge clk); chk_valid = 0; snp_valid = 1; snp_addr = 16'd65;
        @(negedge clk); snp_valid = 0; cyc = 1;
        while (!chk_done && cyc < 40) begin @(negedge clk); cyc++; end
        check("R2", "clash done timing", cyc, 4);
        check("R10", "clash snooped", snooped, 8'h02);
        check("R10", "clash possible", possible, 8'h02);
        check("R10", "clash reexec", reexec, 8'h00);
        check("R8", "clash squash", squash_req, 0);
        m_sn[1] = 1; m_po[1] = 1;
        do_snoop(16'd70);
        check("R10", "second snoop reexec", reexec, 8'h02);
        run_scan("R6 snooped load", 0, 16'd11, 16'd64, 16'd64, 0);

        // R2 request ignored while busy
        chk_valid = 1; chk_store = 1; chk_seq = 16'd11; chk_lo = 16'd0; chk_hi = 16'd0; chk_pos = 0;
        @(negedge clk); chk_lo = 16'd64; chk_hi = 16'd64; cyc = 0;
        @(negedge clk); chk_valid = 0; cyc = 1;
        while (!chk_done && cyc < 40) begin @(negedge clk); cyc++; end
        check("R2", "busy-ignore timing", cyc, 4);
        @(negedge clk);
        check("R2", "no second scan", chk_busy, 0);
        check("R5", "ignored request count", viol_count, mcnt);
        do_ack();
        check("R7", "ack clears", viol_valid, 0);

        // R7 wrap-aware age
        wr_ent(0, 16'hFFF0, 16'd0,  16'd0,  1, 0, 0);
        wr_ent(1, 16'hFFFE, 16'd40, 16'd41, 1, 0, 1);
        wr_ent(2, 16'h0002, 16'd40, 16'd41, 1, 0, 1);
        set_tail(3);
        run_scan("R7 wrap first", 1, 16'hFFF1, 16'd40, 16'd40, 0);
        run_scan("R7 wrap keep older", 1, 16'hFFFF, 16'd40, 16'd40, 1);
        do_ack();

        // R3 block-granular inclusive compare
        wr_ent(1, 16'd5, 16'd16, 16'd16, 1, 0, 1);
        set_tail(2);
        run_scan("R3 below block", 1, 16'd4, 16'd8, 16'd15, 0);
        run_scan("R3 same block", 1, 16'd4, 16'd23, 16'd30, 0);
        run_scan("R3 block above", 1, 16'd4, 16'd24, 16'd30, 0);

        // R4/R5 skipped and unexecuted entries
        wr_ent(1, 16'd20, 16'd80, 16'd83, 1, 1, 1);
        wr_ent(2, 16'd22, 16'd80, 16'd83, 0, 0, 1);
        wr_ent(3, 16'd2,  16'd80, 16'd83, 1, 0, 1);
        wr_ent(4, 16'd24, 16'd80, 16'd83, 1, 0, 0);
        set_tail(5);
        run_scan("R4 skips", 1, 16'd19, 16'd80, 16'd80, 0);
        run_scan("R5 empty scan", 1, 16'd19, 16'd80, 16'd80, 4);

        // Random sweep, R5 R6 R9 R10 R11
        for (int it = 0; it < 400; it++) begin
            logic [15:0] base = 16'($urandom);
            for (int i = 0; i < D; i++) begin
                logic [15:0] lo = 16'($urandom % 256);
                wr_ent(i, base + 16'(2 * i), lo, lo + 16'($urandom % 12),
                       ($urandom % 8) != 0, ($urandom % 8) == 0, $urandom % 2);
            end
            check("R11", "marks cleared", {snooped, possible, reexec}, 0);
            set_tail($urandom % D);
            for (int k = 0; k < 2; k++) begin
                int pos = $urandom % D;
                logic [15:0] lo = 16'($urandom % 256);
                logic [15:0] sq = (($urandom % 4) == 0) ? 16'($urandom) : base + 16'(2 * pos + 1);
                for (int s = 0; s < int'($urandom % 3); s++) do_snoop(16'($urandom % 288));
                if (($urandom % 4) == 0) do_ack();
                run_scan("R5/R6 sweep", $urandom % 2, sq, lo, lo + 16'($urandom % 16), pos);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule